// File: doc/BRIEF.md
# Timer Input Capture Unit

This block time-stamps external events. A free-running counter value enters as a plain input. When a chosen event source shows the selected transition, the block copies that value into a capture register. The event source is either an external pin or the output of an on-chip comparator. The source passes through a two-stage synchronizer, then an optional noise filter, and then an edge detector whose polarity can be selected. Each capture sets a flag. When the interrupt enable is on, the flag drives an interrupt request.

Software reaches the block over an 8-bit bus. The bus can read and write a control register, read the status flag and clear it by writing a one, and read the capture register. A read of the low byte of the capture register copies the high byte into a holding latch. The following high-byte read returns that latch, so the two halves always come from the same capture. An interrupt-acknowledge input stands for the moment the interrupt is executed, and it also clears the flag.

Bus map (address: content): 0 is control (bit0 selects the comparator source, bit1 selects the rising edge, bit2 enables the filter, bit3 enables the interrupt). 1 is status (bit0 is the flag). 2 is the capture low byte. 3 is the held capture high byte.

Top module: `tcap_top`

## Requirements
- R1: After a synchronous reset, the control register, the flag, the capture register and `irq` are all zero.
- R2: With control bit0 at 0 the pin is the event source; with bit0 at 1 the comparator input is the source. Transitions on the source that is not selected cause no capture.
- R3: With control bit1 at 1 only rising transitions capture; with bit1 at 0 only falling transitions capture. A transition in the other direction causes no capture.
- R4: With the filter off, a capture loads the counter value that is present at the fourth rising clock edge, counting from the first edge that samples the new input level.
- R5: With the filter on (control bit2 at 1), a level must hold for four consecutive synchronized samples before it passes. This delays a capture by four more clocks, to the eighth edge. A pulse of three cycles or less produces no capture.
- R6: The flag becomes set on the same clock edge that loads the capture register. A later capture while the flag is still set overwrites the register, and the flag stays set.
- R7: `irq` is high whenever the flag is set and control bit3 is 1, and low whenever control bit3 is 0.
- R8: Writing to address 1 with bit0 at 1 clears the flag. Writing with bit0 at 0 leaves the flag unchanged. A capture on the same edge as a clear takes priority, and the flag stays set.
- R9: A one-cycle pulse on `irq_ack` clears the flag.
- R10: A read at address 2 returns the capture low byte and copies the capture high byte into the holding latch. A read at address 3 returns the holding latch, even if a capture happened between the two reads.
- R11: The control register reads back at address 0 in bits 3:0 with zeros above them. The status reads at address 1 as the flag in bit0 with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Free-running counter value |
| pin_in | input | 1 | External event pin (asynchronous) |
| cmp_in | input | 1 | Comparator output used as an alternative event source |
| irq_ack | input | 1 | Interrupt executed; clears the flag |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| irq | output | 1 | Capture interrupt request |

## Verification
The filter level and the edge detector's previous sample are internal state. An error in either shows up at the ports as a missing capture, an extra capture, or a captured value that is off by a whole number of counter steps. The sweep therefore checks the exact captured count, and makes the counter step by 0x0101 every clock so that both bytes move. A stale holding latch shows up only on the high-byte read that immediately follows a low-byte read. A capture is therefore placed on exactly the edge between those two reads. A wrong flag shows on the next status read and at `irq` within one clock.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int BUS_W  = 8;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_STAT  = 2'd1,
        A_CAPLO = 2'd2,
        A_CAPHI = 2'd3
    } icu_addr_e;

    typedef struct packed {
        logic irq_en;   // bit3
        logic filt_en;  // bit2
        logic rise;     // bit1
        logic src_cmp;  // bit0
    } icu_ctrl_t;

    function automatic logic edge_match(input logic prev, input logic cur, input logic rise);
        return rise ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/icu_cond.sv
module icu_cond #(
    parameter int SYNC_N = 2,
    parameter int FILT_N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic filt_en,
    output logic level_o
);

    logic [SYNC_N-1:0] sync_q;
    logic              smp;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_N-2:0], raw};
    end

    assign smp = sync_q[SYNC_N-1];

    generate
        if (FILT_N > 1) begin : g_filt
            logic [FILT_N-1:0] hist_q;
            logic              lvl_q;

            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= {hist_q[FILT_N-2:0], smp};
            end

            always_ff @(posedge clk) begin
                if (rst)              lvl_q <= 1'b0;
                else if (!filt_en)    lvl_q <= smp;
                else if (&hist_q)     lvl_q <= 1'b1;
                else if (~|hist_q)    lvl_q <= 1'b0;
            end

            assign level_o = lvl_q;
        end else begin : g_nofilt
            logic lvl_q;
            logic filt_en_unused;

            assign filt_en_unused = filt_en;

            always_ff @(posedge clk) begin
                if (rst) lvl_q <= 1'b0;
                else     lvl_q <= smp;
            end

            assign level_o = lvl_q;
        end
    endgenerate

endmodule

// File: rtl/icu_edge.sv
module icu_edge
    import icu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic rise,
    output logic hit_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign hit_o = edge_match(prev_q, level, rise);

endmodule

// File: rtl/icu_capture.sv
module icu_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    input  logic [W-1:0] cnt,
    input  logic         clr,
    output logic [W-1:0] cap_o,
    output logic         flag_o
);

    logic [W-1:0] cap_q;
    logic         flag_q;

    always_ff @(posedge clk) begin
        if (rst)      cap_q <= '0;
        else if (hit) cap_q <= cnt;
    end

    // A capture on the same edge as a clear keeps the flag set.
    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/icu_bus.sv
module icu_bus
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cap,
    input  logic              flag,
    output logic [BUS_W-1:0]  rdata,
    output icu_ctrl_t         ctrl_o,
    output logic              flag_clr_o
);

    icu_ctrl_t              ctrl_q;
    logic [BUS_W-1:0]       temp_q;
    logic [BUS_W-CTRL_W-1:0] wdata_unused_hi;
    icu_addr_e              a;

    assign a               = icu_addr_e'(addr);
    assign wdata_unused_hi = wdata[BUS_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst)                       ctrl_q <= '0;
        else if (wr && a == A_CTRL)    ctrl_q <= icu_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)                       temp_q <= '0;
        else if (rd && a == A_CAPLO)   temp_q <= cap[CNT_W-1:BUS_W];
    end

    always_comb begin
        rdata = '0;
        case (a)
            A_CTRL:  rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
            A_STAT:  rdata = {{(BUS_W-1){1'b0}}, flag};
            A_CAPLO: rdata = cap[BUS_W-1:0];
            A_CAPHI: rdata = temp_q;
            default: rdata = '0;
        endcase
    end

    assign flag_clr_o = wr && (a == A_STAT) && wdata[0];
    assign ctrl_o     = ctrl_q;

endmodule

// File: rtl/tcap_top.sv
module tcap_top
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              pin_in,
    input  logic              cmp_in,
    input  logic              irq_ack,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);

    icu_ctrl_t        ctrl_q;
    logic             src_raw;
    logic             level;
    logic             edge_hit;
    logic             wr_clr;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;

    assign src_raw = ctrl_q.src_cmp ? cmp_in : pin_in;

    icu_cond #(.SYNC_N(2), .FILT_N(4)) u_cond (
        .clk     (clk),
        .rst     (rst),
        .raw     (src_raw),
        .filt_en (ctrl_q.filt_en),
        .level_o (level)
    );

    icu_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .rise  (ctrl_q.rise),
        .hit_o (edge_hit)
    );

    icu_capture #(.W(CNT_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .hit    (edge_hit),
        .cnt    (cnt_val),
        .clr    (wr_clr | irq_ack),
        .cap_o  (cap_q),
        .flag_o (flag_q)
    );

    icu_bus u_bus (
        .clk        (clk),
        .rst        (rst),
        .addr       (bus_addr),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .cap        (cap_q),
        .flag       (flag_q),
        .rdata      (bus_rdata),
        .ctrl_o     (ctrl_q),
        .flag_clr_o (wr_clr)
    );

    assign irq = flag_q & ctrl_q.irq_en;

endmodule

// File: rtl/icu_chk.sv
module icu_chk
    import icu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              hit,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cap,
    input logic              flag,
    input logic              irq,
    input logic              irq_en,
    input logic              irq_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!flag && cap == '0 && !irq));

    assert_capture_value_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> cap == $past(cnt));

    assert_flag_with_capture_R6: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);

    assert_cap_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cap));

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && irq_en) |-> irq);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    assert_write_one_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1 && bus_wdata[0] && !hit) |=> !flag);

    assert_write_zero_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && bus_wr && bus_addr == 2'd1 && !bus_wdata[0] && !irq_ack) |=> flag);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !hit) |=> !flag);

    assert_high_byte_held_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd2) |=>
            ((bus_rd && bus_addr == 2'd3) -> (bus_rdata == $past(cap[CNT_W-1:BUS_W]))));

endmodule

bind tcap_top icu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hit       (edge_hit),
    .cnt       (cnt_val),
    .cap       (cap_q),
    .flag      (flag_q),
    .irq       (irq),
    .irq_en    (ctrl_q.irq_en),
    .irq_ack   (irq_ack),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
);

// File: tb/sim_tcap_top.sv
`timescale 1ns/1ps
module sim_tcap_top;

    localparam logic [15:0] STEP = 16'h0101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = 16'h0000;
    logic        pin_in = 1'b0;
    logic        cmp_in = 1'b0;
    logic        irq_ack = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        irq;

    int checks = 0;
    int errs = 0;
    int cyc = 0;
    bit done = 0;
    logic [15:0] last_cap = 16'h0000;

    always #4 clk = ~clk;

    always @(posedge clk) cnt_val <= cnt_val + STEP;

    tcap_top u0 (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .pin_in(pin_in), .cmp_in(cmp_in),
        .irq_ack(irq_ack), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_cap(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_read(2'd2, lo);
        bus_read(2'd3, hi);
        v = {hi, lo};
    endtask

    task automatic read_flag(output logic f);
        logic [7:0] d;
        bus_read(2'd1, d);
        f = d[0];
    endtask

    task automatic setup(input logic [3:0] ctrl, input logic idle);
        bus_write(2'd0, {4'h0, ctrl});
        pin_in = idle; cmp_in = idle;
        wait_n(12);
        bus_write(2'd1, 8'h01);
    endtask

    task automatic run_combo(input bit s, input bit f, input bit r);
        logic [3:0]  ctrl;
        logic [7:0]  d;
        logic [15:0] c0, v, exp;
        logic        fl;
        bit          ien;
        ien  = s ^ r;
        ctrl = {ien, f, r, s};
        setup(ctrl, !r);
        bus_read(2'd0, d);
        chk("R11 ctrl readback", {8'h00, d}, {12'h000, ctrl});
        c0 = cnt_val;
        if (s) cmp_in = r; else pin_in = r;
        wait_n(12);
        read_cap(v);
        exp = c0 + STEP * (f ? 16'd7 : 16'd3);
        chk(f ? "R5 filtered capture value" : "R4 capture value", v, exp);
        read_flag(fl);
        chk("R6 flag after capture", {15'h0, fl}, 16'h0001);
        chk("R7 irq vs enable", {15'h0, irq}, {15'h0, ien});
        pin_in = 1'b0; cmp_in = 1'b0;
        wait_n(12);
        bus_write(2'd1, 8'h01);
        last_cap = exp;
    endtask

    initial begin
        logic [7:0]  d;
        logic [15:0] v, c0, exp;
        logic        fl;

        wait_n(3);
        rst = 1'b0;
        bus_read(2'd0, d); chk("R1 ctrl reset", {8'h0, d}, 16'h0000);
        bus_read(2'd1, d); chk("R1 status reset", {8'h0, d}, 16'h0000);
        read_cap(v);       chk("R1 capture reset", v, 16'h0000);
        chk("R1 irq reset", {15'h0, irq}, 16'h0000);

        // Sweep source, filter and edge polarity.
        for (int s = 0; s < 2; s++)
            for (int f = 0; f < 2; f++)
                for (int r = 0; r < 2; r++)
                    run_combo(s[0], f[0], r[0]);

        // R2: the source that is not selected is ignored.
        setup(4'b0010, 1'b0);
        cmp_in = 1'b1; wait_n(12);
        read_flag(fl); chk("R2 unselected comparator ignored", {15'h0, fl}, 16'h0000);
        read_cap(v);   chk("R2 capture unchanged", v, last_cap);
        setup(4'b0011, 1'b0);
        pin_in = 1'b1; wait_n(12);
        read_flag(fl); chk("R2 unselected pin ignored", {15'h0, fl}, 16'h0000);

        // R3: the opposite edge is ignored.
        setup(4'b0010, 1'b1);
        pin_in = 1'b0; wait_n(12);
        read_flag(fl); chk("R3 falling ignored when rising selected", {15'h0, fl}, 16'h0000);
        setup(4'b0000, 1'b0);
        pin_in = 1'b1; wait_n(12);
        read_flag(fl); chk("R3 rising ignored when falling selected", {15'h0, fl}, 16'h0000);

        // R5: a 3-cycle pulse is rejected with the filter on and accepted with it off.
        setup(4'b0110, 1'b0);
        pin_in = 1'b1; wait_n(3); pin_in = 1'b0; wait_n(12);
        read_flag(fl); chk("R5 short pulse filtered", {15'h0, fl}, 16'h0000);
        setup(4'b0010, 1'b0);
        c0 = cnt_val;
        pin_in = 1'b1; wait_n(3); pin_in = 1'b0; wait_n(12);
        read_flag(fl); chk("R5 short pulse passes unfiltered", {15'h0, fl}, 16'h0001);
        read_cap(v);   chk("R4 short pulse capture value", v, c0 + STEP * 16'd3);
        last_cap = c0 + STEP * 16'd3;

        // R8: writing 0 keeps the flag; writing 1 clears it.
        bus_write(2'd1, 8'hFE);
        read_flag(fl); chk("R8 write zero keeps flag", {15'h0, fl}, 16'h0001);
        bus_write(2'd1, 8'h01);
        read_flag(fl); chk("R8 write one clears flag", {15'h0, fl}, 16'h0000);

        // R6: overwrite while the flag is set.
        setup(4'b1010, 1'b0);
        pin_in = 1'b1; wait_n(12);
        pin_in = 1'b0; wait_n(12);
        c0 = cnt_val;
        pin_in = 1'b1; wait_n(12);
        read_cap(v);   chk("R6 overwrite value", v, c0 + STEP * 16'd3);
        read_flag(fl); chk("R6 flag stays set", {15'h0, fl}, 16'h0001);
        chk("R7 irq high with enable", {15'h0, irq}, 16'h0001);
        last_cap = c0 + STEP * 16'd3;

        // R9: interrupt acknowledge clears the flag.
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        read_flag(fl); chk("R9 ack clears flag", {15'h0, fl}, 16'h0000);
        chk("R9 irq low after ack", {15'h0, irq}, 16'h0000);

        // R10: a capture lands between the low-byte and high-byte reads.
        setup(4'b0010, 1'b0);
        c0 = cnt_val;
        pin_in = 1'b1;
        wait_n(3);
        read_cap(v);
        chk("R10 pair returns previous capture", v, last_cap);
        exp = c0 + STEP * 16'd3;
        read_cap(v);
        chk("R10 next pair returns new capture", v, exp);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule